// File: doc/BRIEF.md
# Fully Associative TLB with Protection Check

This block is a small translation lookaside buffer in which every entry is compared in parallel against the incoming virtual page number. A lookup carries an access kind: read, write or execute. The block returns, in the same cycle, a hit flag, the physical page number of the matching entry, a protection-fault flag and the stored modified bit of that entry.

Each entry holds the following fields:
- a valid flag
- a virtual page tag
- a modified bit
- a two-bit protection class
- a physical page number

A fill port installs an entry, either at an index that the caller names or at a target that the block selects. An invalidate port clears one entry or all entries. A write that completes without a fault marks its entry as modified, so that later page-out logic can see that the page is dirty. Page-table walks and the delivery of exceptions are left to the surrounding logic. The block only reports a miss or a fault.

Top module: `tlb_assoc`

## Requirements
- R1: When `lk_valid_i` is 1 and a valid entry's tag equals `lk_vpn_i`, `lk_hit_o` is 1 in the same cycle and `lk_ppn_o` gives that entry's physical page. When several valid entries match, the lowest-indexed one is used.
- R2: An entry whose valid flag is 0 never hits, even when its tag matches. On a miss, and whenever `lk_valid_i` is 0, `lk_hit_o`, `lk_fault_o`, `lk_dirty_o` and `lk_ppn_o` are all 0.
- R3: Protection codes are 00 read-write, 01 read-execute, 10 read-only and 11 reserved. Access codes are 00 read, 01 write and 10 execute, and 11 behaves as read. A read that hits any of the three defined classes does not fault. Any access that hits a reserved entry faults.
- R4: A write that hits a read-only or read-execute entry sets `lk_fault_o`. A write completes only on a read-write entry.
- R5: An execute access that hits an entry with any class other than read-execute sets `lk_fault_o`.
- R6: A write hit that does not fault sets that entry's modified bit at the next clock edge. A faulted write leaves the bit unchanged. `lk_dirty_o` shows the stored bit of the hit entry as it was before that edge.
- R7: A fill takes effect at the next edge and chooses its target in this order: the index `fill_idx_i` when `fill_idx_vld_i` is 1; otherwise the lowest-numbered invalid entry; otherwise a round-robin pointer. The pointer starts at 0 and advances by one (wrapping) only when it is used.
- R8: `inv_i` clears the valid flag of entry `inv_idx_i` at the next edge, and `inv_all_i` clears every entry. When a fill happens in the same cycle, the fill's target ends up valid with the new contents. A write hit to the entry being filled loses to the fill.
- R9: While `rst_ni` is low, every valid flag is cleared and the round-robin pointer returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_vpn_i | input | VPN_W | Virtual page number to translate |
| lk_acc_i | input | 2 | Access kind |
| lk_hit_o | output | 1 | Lookup hit |
| lk_ppn_o | output | PPN_W | Physical page of the hit entry |
| lk_fault_o | output | 1 | Protection fault on the hit entry |
| lk_dirty_o | output | 1 | Stored modified bit of the hit entry |
| fill_i | input | 1 | Install an entry |
| fill_idx_vld_i | input | 1 | Use `fill_idx_i` as the target |
| fill_idx_i | input | IDX_W | Explicit fill target |
| fill_vpn_i | input | VPN_W | Tag to install |
| fill_ppn_i | input | PPN_W | Physical page to install |
| fill_prot_i | input | 2 | Protection class to install |
| fill_dirty_i | input | 1 | Initial modified bit |
| inv_i | input | 1 | Invalidate one entry |
| inv_idx_i | input | IDX_W | Entry to invalidate |
| inv_all_i | input | 1 | Invalidate all entries |

## Verification
The bench targets these corner cases:

- **Stale tags.** An entry that was invalidated still holds a matching tag. A design that ignores the valid flag would report a hit and a physical page for it.
- **Protection edges.** A write to read-only, a write to read-execute, an execute on read-write, and any access to the reserved class. A permission table with one wrong cell lets the access through, or faults a legal read.
- **Modified-bit timing.** The bench checks the bit after a faulted write and after a clean write. A design that sets the bit on the faulted write, or that does not set it on the clean write, shows the wrong `lk_dirty_o` on the following read.
- **Fill targeting.** The bench checks fill targeting when the buffer is full, including a fill racing an invalidate-all. A wrong priority or a pointer that always advances evicts the wrong translation, which shows up as a miss on a page that should hit.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    PROT_RW  = 2'b00,
    PROT_RX  = 2'b01,
    PROT_RO  = 2'b10,
    PROT_RSV = 2'b11
  } prot_e;

  typedef enum logic [1:0] {
    ACC_RD  = 2'b00,
    ACC_WR  = 2'b01,
    ACC_EX  = 2'b10,
    ACC_RD2 = 2'b11
  } acc_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 31,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0]            valid_i,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tags_i,
  input  logic [VPN_W-1:0]              vpn_i,
  output logic                          hit_o,
  output logic [IDX_W-1:0]              idx_o
);
  logic [ENTRIES-1:0] eq;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign eq[g] = valid_i[g] && (tags_i[g] == vpn_i);
  end

  // lowest index wins on duplicate tags
  always_comb begin
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (eq[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |eq;
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
  import tlb_pkg::*;
(
  input  prot_e prot_i,
  input  acc_e  acc_i,
  output logic  fault_o
);
  always_comb begin
    unique case (acc_i)
      ACC_WR:  fault_o = (prot_i != PROT_RW);
      ACC_EX:  fault_o = (prot_i != PROT_RX);
      default: fault_o = (prot_i == PROT_RSV);
    endcase
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fill_i,
  input  logic               idx_vld_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [ENTRIES-1:0] valid_i,
  output logic [IDX_W-1:0]   tgt_o
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;
  logic             use_ptr;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign use_ptr = !idx_vld_i && !any_free;
  assign tgt_o   = idx_vld_i ? idx_i : (any_free ? free_idx : ptr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (fill_i && use_ptr) begin
      ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 31,
  parameter int PPN_W   = 22,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lk_valid_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  input  logic [1:0]       lk_acc_i,
  output logic             lk_hit_o,
  output logic [PPN_W-1:0] lk_ppn_o,
  output logic             lk_fault_o,
  output logic             lk_dirty_o,
  input  logic             fill_i,
  input  logic             fill_idx_vld_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic [1:0]       fill_prot_i,
  input  logic             fill_dirty_i,
  input  logic             inv_i,
  input  logic [IDX_W-1:0] inv_idx_i,
  input  logic             inv_all_i
);
  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0]            dirty_q;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  prot_e                         prot_q [ENTRIES];

  logic             tag_hit;
  logic [IDX_W-1:0] hit_idx;
  prot_e            hit_prot;
  logic             perm_fault;
  logic             wr_set;
  logic [IDX_W-1:0] fill_tgt;

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
    .valid_i (valid_q),
    .tags_i  (vpn_q),
    .vpn_i   (lk_vpn_i),
    .hit_o   (tag_hit),
    .idx_o   (hit_idx)
  );

  assign hit_prot = prot_q[hit_idx];

  tlb_perm u_perm (
    .prot_i  (hit_prot),
    .acc_i   (acc_e'(lk_acc_i)),
    .fault_o (perm_fault)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fill_i    (fill_i),
    .idx_vld_i (fill_idx_vld_i),
    .idx_i     (fill_idx_i),
    .valid_i   (valid_q),
    .tgt_o     (fill_tgt)
  );

  assign lk_hit_o   = lk_valid_i && tag_hit;
  assign lk_fault_o = lk_hit_o && perm_fault;
  assign lk_ppn_o   = lk_hit_o ? ppn_q[hit_idx] : '0;
  assign lk_dirty_o = lk_hit_o && dirty_q[hit_idx];
  assign wr_set     = lk_hit_o && !perm_fault && (acc_e'(lk_acc_i) == ACC_WR);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic is_tgt;
    assign is_tgt = fill_i && (fill_tgt == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
      end else if (is_tgt) begin
        valid_q[g] <= 1'b1;
      end else if (inv_all_i || (inv_i && inv_idx_i == IDX_W'(g))) begin
        valid_q[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk_i) begin
      if (is_tgt) begin
        vpn_q[g]   <= fill_vpn_i;
        ppn_q[g]   <= fill_ppn_i;
        prot_q[g]  <= prot_e'(fill_prot_i);
        dirty_q[g] <= fill_dirty_i;
      end else if (wr_set && hit_idx == IDX_W'(g)) begin
        dirty_q[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlb_assoc_chk.sv
module tlb_assoc_chk #(
  parameter int ENTRIES = 4,
  parameter int PPN_W   = 22,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         lk_acc_i,
  input logic               lk_hit_o,
  input logic [PPN_W-1:0]   lk_ppn_o,
  input logic               lk_fault_o,
  input logic               fill_i,
  input logic               inv_all_i,
  input logic [IDX_W-1:0]   hit_idx,
  input logic [1:0]         hit_prot,
  input logic [IDX_W-1:0]   fill_tgt,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] dirty_q
);
  AST_MISS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> (!lk_fault_o && lk_ppn_o == '0)); // R2

  AST_RSV_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_hit_o && hit_prot == 2'b11) |-> lk_fault_o); // R3

  AST_WR_NEEDS_RW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_hit_o && lk_acc_i == 2'b01 && hit_prot != 2'b00) |-> lk_fault_o); // R4

  AST_EX_NEEDS_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_hit_o && lk_acc_i == 2'b10 && hit_prot != 2'b01) |-> lk_fault_o); // R5

  AST_DIRTY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_hit_o && lk_acc_i == 2'b01 && !lk_fault_o && !fill_i) |=> dirty_q[$past(hit_idx)]); // R6

  AST_FILL_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |=> valid_q[$past(fill_tgt)]); // R7

  AST_INV_ALL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_all_i && !fill_i) |=> (valid_q == '0)); // R8

  AST_ONE_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_all_i && fill_i) |=> $onehot(valid_q)); // R8
endmodule

bind tlb_assoc tlb_assoc_chk #(.ENTRIES(ENTRIES), .PPN_W(PPN_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lk_acc_i   (lk_acc_i),
  .lk_hit_o   (lk_hit_o),
  .lk_ppn_o   (lk_ppn_o),
  .lk_fault_o (lk_fault_o),
  .fill_i     (fill_i),
  .inv_all_i  (inv_all_i),
  .hit_idx    (hit_idx),
  .hit_prot   (hit_prot),
  .fill_tgt   (fill_tgt),
  .valid_q    (valid_q),
  .dirty_q    (dirty_q)
);

// File: tb/tlb_assoc_bench.sv
module tlb_assoc_bench;
  localparam int ENTRIES = 4;
  localparam int VPN_W   = 31;
  localparam int PPN_W   = 22;
  localparam int IDX_W   = 2;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             lk_valid_i = 1'b0;
  logic [VPN_W-1:0] lk_vpn_i = '0;
  logic [1:0]       lk_acc_i = '0;
  logic             lk_hit_o;
  logic [PPN_W-1:0] lk_ppn_o;
  logic             lk_fault_o;
  logic             lk_dirty_o;
  logic             fill_i = 1'b0;
  logic             fill_idx_vld_i = 1'b0;
  logic [IDX_W-1:0] fill_idx_i = '0;
  logic [VPN_W-1:0] fill_vpn_i = '0;
  logic [PPN_W-1:0] fill_ppn_i = '0;
  logic [1:0]       fill_prot_i = '0;
  logic             fill_dirty_i = 1'b0;
  logic             inv_i = 1'b0;
  logic [IDX_W-1:0] inv_idx_i = '0;
  logic             inv_all_i = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  bit             m_valid [ENTRIES];
  bit             m_dirty [ENTRIES];
  bit [VPN_W-1:0] m_vpn   [ENTRIES];
  bit [PPN_W-1:0] m_ppn   [ENTRIES];
  bit [1:0]       m_prot  [ENTRIES];
  int             m_ptr;

  always #10 clk_i = ~clk_i;

  tlb_assoc #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_tlb_assoc (.*);

  function automatic bit exp_fault(bit [1:0] prot, bit [1:0] acc);
    if (prot == 2'b11) return 1'b1;
    if (acc == 2'b01) return prot != 2'b00;
    if (acc == 2'b10) return prot != 2'b01;
    return 1'b0;
  endfunction

  function automatic int exp_idx(bit [VPN_W-1:0] vpn);
    for (int i = 0; i < ENTRIES; i++)
      if (m_valid[i] && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  task automatic cmp(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // check comb outputs, then advance model and design by one edge
  task automatic step(string req);
    int  hi, tgt;
    bit  hit, flt, wr_set, use_ptr;
    string freq;
    #1;
    hi  = lk_valid_i ? exp_idx(lk_vpn_i) : -1;
    hit = (hi >= 0);
    flt = hit && exp_fault(m_prot[hi], lk_acc_i);
    if (req != "") freq = req;
    else if (hit && m_prot[hi] == 2'b11) freq = "R3";
    else if (lk_acc_i == 2'b01) freq = "R4";
    else if (lk_acc_i == 2'b10) freq = "R5";
    else freq = "R3";
    cmp(req != "" ? req : (hit ? "R1" : "R2"), "hit", lk_hit_o, hit);
    cmp(req != "" ? req : "R1", "ppn", lk_ppn_o, hit ? m_ppn[hi] : 0);
    cmp(freq, "fault", lk_fault_o, flt);
    cmp(req != "" ? req : "R6", "dirty", lk_dirty_o, hit ? m_dirty[hi] : 0);
    wr_set = hit && !flt && lk_acc_i == 2'b01;
    tgt = -1; use_ptr = 1'b0;
    if (fill_i) begin
      if (fill_idx_vld_i) tgt = fill_idx_i;
      else begin
        for (int i = ENTRIES - 1; i >= 0; i--) if (!m_valid[i]) tgt = i;
        if (tgt < 0) begin tgt = m_ptr; use_ptr = 1'b1; end
      end
    end
    @(posedge clk_i);
    if (inv_all_i) for (int i = 0; i < ENTRIES; i++) m_valid[i] = 1'b0;
    else if (inv_i) m_valid[inv_idx_i] = 1'b0;
    if (wr_set) m_dirty[hi] = 1'b1;
    if (tgt >= 0) begin
      m_valid[tgt] = 1'b1; m_vpn[tgt] = fill_vpn_i; m_ppn[tgt] = fill_ppn_i;
      m_prot[tgt] = fill_prot_i; m_dirty[tgt] = fill_dirty_i;
    end
    if (use_ptr) m_ptr = (m_ptr + 1) % ENTRIES;
    @(negedge clk_i);
  endtask

  task automatic idle();
    lk_valid_i = 0; fill_i = 0; fill_idx_vld_i = 0; inv_i = 0; inv_all_i = 0;
  endtask

  task automatic look(int vpn, bit [1:0] acc, string req);
    idle(); lk_valid_i = 1; lk_vpn_i = VPN_W'(vpn); lk_acc_i = acc; step(req);
  endtask

  task automatic fill(int vpn, int ppn, bit [1:0] prot, int idx, string req);
    idle(); fill_i = 1; fill_vpn_i = VPN_W'(vpn); fill_ppn_i = PPN_W'(ppn);
    fill_prot_i = prot; fill_dirty_i = 0;
    if (idx >= 0) begin fill_idx_vld_i = 1; fill_idx_i = IDX_W'(idx); end
    step(req);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    for (int i = 0; i < ENTRIES; i++) begin
      m_valid[i] = 0; m_dirty[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; m_prot[i] = 0;
    end
    m_ptr = 0;
    repeat (3) @(negedge clk_i);
    look(0, 2'b00, "R9");   // reset: nothing hits
    rst_ni = 1'b1;
    @(negedge clk_i);
    look(0, 2'b00, "R9");
    // fills land in lowest invalid slots, then round robin
    fill(10, 'h100, 2'b00, -1, "R7");
    fill(11, 'h101, 2'b01, -1, "R7");
    fill(12, 'h102, 2'b10, -1, "R7");
    fill(13, 'h103, 2'b11, -1, "R7");
    fill(14, 'h104, 2'b00, -1, "R7");   // evicts slot 0
    look(10, 2'b00, "R7");
    look(14, 2'b00, "R7");
    fill(15, 'h105, 2'b00, -1, "R7");   // evicts slot 1
    look(11, 2'b00, "R7");
    fill(20, 'h120, 2'b00, 3, "R7");    // explicit slot 3
    look(13, 2'b00, "R7");
    look(20, 2'b00, "R7");
    // protection classes
    look(12, 2'b01, "R4");
    look(12, 2'b10, "R5");
    look(12, 2'b00, "R3");
    fill(30, 'h130, 2'b01, 2, "R4");
    look(30, 2'b01, "R4");
    look(30, 2'b10, "R5");
    look(14, 2'b10, "R5");
    fill(31, 'h131, 2'b11, 2, "R3");
    look(31, 2'b00, "R3");
    // modified bit
    look(14, 2'b01, "R6");
    look(14, 2'b00, "R6");
    fill(32, 'h132, 2'b10, 1, "R6");
    look(32, 2'b01, "R6");
    look(32, 2'b00, "R6");
    // invalidation
    idle(); inv_i = 1; inv_idx_i = 0; step("R8");
    look(14, 2'b00, "R2");
    idle(); inv_all_i = 1; fill_i = 1; fill_idx_vld_i = 1; fill_idx_i = 2;
    fill_vpn_i = 40; fill_ppn_i = 'h140; fill_prot_i = 0; fill_dirty_i = 0; step("R8");
    look(40, 2'b00, "R8");
    look(20, 2'b00, "R8");
    look(15, 2'b00, "R2");
    idle(); inv_all_i = 1; step("R8");
    look(40, 2'b00, "R8");
    // random mix, small tag space to force hits and duplicates
    for (int n = 0; n < 3000; n++) begin
      idle();
      lk_valid_i     = ($urandom % 4) != 0;
      lk_vpn_i       = VPN_W'($urandom % 8);
      lk_acc_i       = 2'($urandom % 4);
      fill_i         = ($urandom % 4) == 0;
      fill_idx_vld_i = ($urandom % 3) == 0;
      fill_idx_i     = IDX_W'($urandom % ENTRIES);
      fill_vpn_i     = VPN_W'($urandom % 8);
      fill_ppn_i     = PPN_W'($urandom);
      fill_prot_i    = 2'($urandom % 4);
      fill_dirty_i   = 1'($urandom % 2);
      inv_i          = ($urandom % 10) == 0;
      inv_idx_i      = IDX_W'($urandom % ENTRIES);
      inv_all_i      = ($urandom % 40) == 0;
      step("");
    end
    idle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule